// File: doc/BRIEF.md
# Buck Regulator Fault Protection Supervisor

This block decides, one clock at a time, how a buck regulator reacts to its protection comparators. It receives raw flags for overcurrent, feedback above the overvoltage trip level, feedback below the overvoltage release level, and undervoltage. It also takes a hot flag and a cool flag for die temperature, an enable-low flag and a supply power-on-reset flag. It drives four outputs: a switching enable, a power-good pull-down request, a low-side discharge command and a status code naming the fault.

Each of the four voltage and current flags must hold for a programmable number of clock cycles before it counts. The count stands for the 2 µs qualification window at the system clock rate. Overcurrent and undervoltage latch the converter off until enable goes low or supply power-on-reset occurs. Overvoltage latches harder: only supply power-on-reset releases it. While it is held, the low-side switch is cycled with hysteresis to bleed the output down. Over-temperature only suspends switching. It does not touch power-good and releases by itself once the die cools.

Top module: `fault_supervisor`

## Requirements
- R1: The overcurrent, overvoltage-trip, overvoltage-release and undervoltage flags take effect only after being sampled high on DEGLITCH_CYC consecutive rising clock edges. A single low sample restarts the count. A run of DEGLITCH_CYC-1 samples never takes effect.
- R2: A qualified overcurrent or undervoltage flag latches a fault. The fault drives switch_en low and pgood_pulldown high. It is cleared by en_low or vcc_por_low. While en_low is high, no new overcurrent or undervoltage fault can latch.
- R3: A qualified overvoltage-trip flag latches a fault that drives switch_en low and pgood_pulldown high. en_low has no effect on it. Only vcc_por_low clears it.
- R4: lowside_dischg is high only while the overvoltage fault is held. It turns on in the cycle the trip flag qualifies and turns off when the release flag qualifies. It turns on again on each further qualified trip.
- R5: A high temp_hot sample enters suspend, driving switch_en low while pgood_pulldown keeps its value. Suspend ends on a temp_cool sample, on en_low or on vcc_por_low, after which switching resumes if nothing else is latched.
- R6: During suspend the other protections stay active. An undervoltage qualified while suspended still latches and raises pgood_pulldown.
- R7: fault_code uses these values: 0 means none, 1 overcurrent, 2 overvoltage, 3 undervoltage, 4 over-temperature. It keeps the first fault captured while that fault stays set. When that fault clears, the code moves to the highest remaining one, in the order 1, 2, 3, 4. The same order breaks ties between faults captured in the same cycle.
- R8: vcc_por_low clears every latch, the suspend state, the discharge output and every qualification counter. It overrides all other inputs on the same edge.
- R9: After synchronous reset, switch_en is 1, pgood_pulldown is 0, lowside_dischg is 0 and fault_code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_raw | input | 1 | Overcurrent comparator flag |
| ov_trip_raw | input | 1 | Feedback above overvoltage trip level (116%) |
| ov_rel_raw | input | 1 | Feedback below overvoltage release level (102%) |
| uv_raw | input | 1 | Feedback below undervoltage level (84%) |
| temp_hot | input | 1 | Die above rising over-temperature threshold |
| temp_cool | input | 1 | Die below hysteresis threshold |
| en_low | input | 1 | Enable pin below its falling threshold |
| vcc_por_low | input | 1 | Supply below falling power-on-reset threshold |
| switch_en | output | 1 | Modulator may switch |
| pgood_pulldown | output | 1 | Request to pull power-good low |
| lowside_dischg | output | 1 | Low-side switch discharge command |
| fault_code | output | 3 | Status code of the reported fault |

## Verification
The assertions assume that all comparator flags are already synchronous to clk and free of metastability. They also assume that temp_hot and temp_cool are never high together, since physical thresholds with hysteresis make that impossible. The stimulus changes inputs only just after falling clock edges. It raises each flag as a clean run of a chosen length and never drives both temperature flags at once. Pulse widths are placed exactly one below and exactly at the qualification count, so the boundary is probed without relying on undefined overlaps.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [2:0] {
        FC_NONE = 3'd0,
        FC_OC   = 3'd1,
        FC_OV   = 3'd2,
        FC_UV   = 3'd3,
        FC_OT   = 3'd4
    } fault_code_e;

    localparam int NQ    = 4;
    localparam int Q_OC  = 0;
    localparam int Q_OVT = 1;
    localparam int Q_OVR = 2;
    localparam int Q_UV  = 3;

    typedef struct packed {
        logic oc;
        logic ov;
        logic uv;
        logic ot;
    } fault_set_t;

    function automatic logic code_live(fault_code_e c, fault_set_t s);
        case (c)
            FC_OC:   return s.oc;
            FC_OV:   return s.ov;
            FC_UV:   return s.uv;
            FC_OT:   return s.ot;
            default: return 1'b0;
        endcase
    endfunction

    function automatic fault_code_e code_pick(fault_set_t s);
        if (s.oc)      return FC_OC;
        else if (s.ov) return FC_OV;
        else if (s.uv) return FC_UV;
        else if (s.ot) return FC_OT;
        else           return FC_NONE;
    endfunction

endpackage

// File: rtl/fps_deglitch.sv
module fps_deglitch #(
    parameter int HOLD = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic raw,
    output logic qual
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || clr || !raw)
            run_cnt <= '0;
        else if (run_cnt != CW'(HOLD))
            run_cnt <= run_cnt + 1'b1;
    end

    assign qual = (run_cnt == CW'(HOLD));

    // R1: a qualified flag was sampled high on the previous edge
    p_qual_after_high_r1: assert property (@(posedge clk) disable iff (rst)
        qual |-> $past(raw));

    // R1: any low sample drops qualification on the next cycle
    p_low_restarts_r1: assert property (@(posedge clk) disable iff (rst)
        !raw |=> !qual);

endmodule

// File: rtl/fps_core.sv
module fps_core
    import fps_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        q_oc,
    input  logic        q_ovt,
    input  logic        q_ovr,
    input  logic        q_uv,
    input  logic        temp_hot,
    input  logic        temp_cool,
    input  logic        en_low,
    input  logic        vcc_por_low,
    output logic        switch_en,
    output logic        pgood_pulldown,
    output logic        lowside_dischg,
    output fault_code_e code
);
    fault_set_t  st, st_nx;
    logic        dis, dis_nx;
    fault_code_e code_nx;

    always_comb begin
        st_nx = st;
        if (vcc_por_low) begin
            st_nx = '0;
        end else begin
            if (en_low) begin
                st_nx.oc = 1'b0;
                st_nx.uv = 1'b0;
                st_nx.ot = 1'b0;
            end else begin
                if (q_oc)          st_nx.oc = 1'b1;
                if (q_uv)          st_nx.uv = 1'b1;
                if (temp_hot)      st_nx.ot = 1'b1;
                else if (temp_cool) st_nx.ot = 1'b0;
            end
            if (q_ovt) st_nx.ov = 1'b1;
        end
    end

    always_comb begin
        if (vcc_por_low || !st_nx.ov) dis_nx = 1'b0;
        else if (q_ovt)               dis_nx = 1'b1;
        else if (q_ovr)               dis_nx = 1'b0;
        else                          dis_nx = dis;
    end

    always_comb begin
        if (vcc_por_low)             code_nx = FC_NONE;
        else if (code_live(code, st_nx)) code_nx = code;
        else                         code_nx = code_pick(st_nx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            dis  <= 1'b0;
            code <= FC_NONE;
        end else begin
            st   <= st_nx;
            dis  <= dis_nx;
            code <= code_nx;
        end
    end

    assign switch_en      = !(st.oc || st.ov || st.uv || st.ot);
    assign pgood_pulldown = st.oc || st.ov || st.uv;
    assign lowside_dischg = dis;

    // R3: enable going low never releases the overvoltage latch
    p_ov_held_r3: assert property (@(posedge clk) disable iff (rst)
        (st.ov && !vcc_por_low) |=> st.ov);

    // R2: enable low releases overcurrent and undervoltage
    p_en_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (en_low && !vcc_por_low) |=> (!st.oc && !st.uv));

    // R4: discharge only while the overvoltage latch is held
    p_dis_in_ov_r4: assert property (@(posedge clk) disable iff (rst)
        lowside_dischg |-> st.ov);

    // R8: supply reset wipes everything on the next cycle
    p_por_clears_r8: assert property (@(posedge clk) disable iff (rst)
        vcc_por_low |=> (st == '0 && !lowside_dischg && code == FC_NONE));

    // R7: an undervoltage code is kept until its own clear paths act
    p_uv_code_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (code == FC_UV && !en_low && !vcc_por_low) |=> code == FC_UV);

    // R5: entering suspend leaves power-good untouched when no other fault rises
    p_ot_keeps_pg_r5: assert property (@(posedge clk) disable iff (rst)
        (temp_hot && !en_low && !vcc_por_low && !q_oc && !q_ovt && !q_uv)
        |=> (!switch_en && $stable(pgood_pulldown)));

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
    import fps_pkg::*;
#(
    parameter int DEGLITCH_CYC = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       oc_raw,
    input  logic       ov_trip_raw,
    input  logic       ov_rel_raw,
    input  logic       uv_raw,
    input  logic       temp_hot,
    input  logic       temp_cool,
    input  logic       en_low,
    input  logic       vcc_por_low,
    output logic       switch_en,
    output logic       pgood_pulldown,
    output logic       lowside_dischg,
    output logic [2:0] fault_code
);
    logic [NQ-1:0] raw_v;
    logic [NQ-1:0] qual_v;
    fault_code_e   code;

    always_comb begin
        raw_v        = '0;
        raw_v[Q_OC]  = oc_raw;
        raw_v[Q_OVT] = ov_trip_raw;
        raw_v[Q_OVR] = ov_rel_raw;
        raw_v[Q_UV]  = uv_raw;
    end

    for (genvar g = 0; g < NQ; g++) begin : g_dg
        fps_deglitch #(.HOLD(DEGLITCH_CYC)) u_dg (
            .clk  (clk),
            .rst  (rst),
            .clr  (vcc_por_low),
            .raw  (raw_v[g]),
            .qual (qual_v[g])
        );
    end

    fps_core u_core (
        .clk            (clk),
        .rst            (rst),
        .q_oc           (qual_v[Q_OC]),
        .q_ovt          (qual_v[Q_OVT]),
        .q_ovr          (qual_v[Q_OVR]),
        .q_uv           (qual_v[Q_UV]),
        .temp_hot       (temp_hot),
        .temp_cool      (temp_cool),
        .en_low         (en_low),
        .vcc_por_low    (vcc_por_low),
        .switch_en      (switch_en),
        .pgood_pulldown (pgood_pulldown),
        .lowside_dischg (lowside_dischg),
        .code           (code)
    );

    assign fault_code = code;

endmodule

// File: tb/test_fault_supervisor.sv
module test_fault_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int D = 12;

    localparam int I_OC = 0, I_OVT = 1, I_OVR = 2, I_UV = 3;
    localparam int I_HOT = 4, I_COOL = 5, I_EN = 6, I_POR = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] drv = '0;
    logic       switch_en, pgood_pulldown, lowside_dischg;
    logic [2:0] fault_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_supervisor #(.DEGLITCH_CYC(D)) i_fault_supervisor (
        .clk            (clk),
        .rst            (rst),
        .oc_raw         (drv[I_OC]),
        .ov_trip_raw    (drv[I_OVT]),
        .ov_rel_raw     (drv[I_OVR]),
        .uv_raw         (drv[I_UV]),
        .temp_hot       (drv[I_HOT]),
        .temp_cool      (drv[I_COOL]),
        .en_low         (drv[I_EN]),
        .vcc_por_low    (drv[I_POR]),
        .switch_en      (switch_en),
        .pgood_pulldown (pgood_pulldown),
        .lowside_dischg (lowside_dischg),
        .fault_code     (fault_code)
    );

    typedef struct {
        string      tag;
        logic [5:0] exp;
    } item_t;

    item_t q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int idx, int w);
        drv[idx] = 1'b1;
        tick(w);
        drv[idx] = 1'b0;
    endtask

    // expected: {switch_en, pgood_pulldown, lowside_dischg, fault_code}
    task automatic expect_out(string tag, logic sw, logic pg, logic ds, logic [2:0] c);
        item_t it;
        it.tag = tag;
        it.exp = {sw, pg, ds, c};
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    // monitor: compares each queued expectation 1 ns after it is pushed
    initial begin
        forever begin
            item_t it;
            logic [5:0] act;
            wait (q.size() > 0);
            #1;
            it  = q.pop_front();
            act = {switch_en, pgood_pulldown, lowside_dischg, fault_code};
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s act=%b exp=%b", it.tag, act, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        expect_out("R9 reset state", 1, 0, 0, 3'd0);

        // R1 boundary: one short of the count, and a restarted run
        pulse(I_OC, D - 1); tick(2);
        expect_out("R1 oc D-1 ignored", 1, 0, 0, 3'd0);
        drv[I_OC] = 1'b1; tick(D - 1); drv[I_OC] = 1'b0; tick(1);
        drv[I_OC] = 1'b1; tick(D - 1); drv[I_OC] = 1'b0; tick(2);
        expect_out("R1 oc gap restarts", 1, 0, 0, 3'd0);
        pulse(I_OVT, D - 1); tick(2);
        expect_out("R1 ov trip D-1 ignored", 1, 0, 0, 3'd0);

        // R2 overcurrent latch and enable clear
        pulse(I_OC, D); tick(1);
        expect_out("R2 oc latched", 0, 1, 0, 3'd1);
        pulse(I_EN, 1); tick(1);
        expect_out("R2 oc cleared by en", 1, 0, 0, 3'd0);

        // R2 enable low blocks new latch
        drv[I_EN] = 1'b1;
        pulse(I_OC, D); tick(1);
        drv[I_EN] = 1'b0; tick(1);
        expect_out("R2 oc blocked by en", 1, 0, 0, 3'd0);

        // R2 undervoltage latch and supply clear
        pulse(I_UV, D); tick(1);
        expect_out("R2 uv latched", 0, 1, 0, 3'd3);
        pulse(I_POR, 1); tick(1);
        expect_out("R2 uv cleared by por", 1, 0, 0, 3'd0);

        // R3 and R4: overvoltage latch and discharge hysteresis
        pulse(I_OVT, D); tick(1);
        expect_out("R3 ov latched dischg on R4", 0, 1, 1, 3'd2);
        pulse(I_EN, 1); tick(1);
        expect_out("R3 en ignored by ov", 0, 1, 1, 3'd2);
        pulse(I_OVR, D - 1); tick(2);
        expect_out("R4 release D-1 keeps dischg", 0, 1, 1, 3'd2);
        pulse(I_OVR, D); tick(1);
        expect_out("R4 dischg off on release", 0, 1, 0, 3'd2);
        pulse(I_OVT, D - 1); tick(2);
        expect_out("R4 retrip D-1 keeps off", 0, 1, 0, 3'd2);
        pulse(I_OVT, D); tick(1);
        expect_out("R4 dischg on again", 0, 1, 1, 3'd2);

        // R7 a later overcurrent does not replace the code; en clears it only
        pulse(I_OC, D); tick(1);
        expect_out("R7 ov code kept after oc", 0, 1, 1, 3'd2);
        pulse(I_EN, 1); tick(1);
        expect_out("R7 ov still reported", 0, 1, 1, 3'd2);
        pulse(I_POR, 1); tick(1);
        expect_out("R3 por clears ov", 1, 0, 0, 3'd0);

        // R5 suspend and resume
        pulse(I_HOT, 1); tick(1);
        expect_out("R5 suspend", 0, 0, 0, 3'd4);
        pulse(I_COOL, 1); tick(1);
        expect_out("R5 resume on cool", 1, 0, 0, 3'd0);
        pulse(I_HOT, 1); tick(1);
        pulse(I_EN, 1); tick(1);
        expect_out("R5 en ends suspend", 1, 0, 0, 3'd0);
        pulse(I_HOT, 1); tick(1);
        pulse(I_POR, 1); tick(1);
        expect_out("R5 por ends suspend", 1, 0, 0, 3'd0);

        // R6 undervoltage during suspend, R7 code handover
        pulse(I_HOT, 1); tick(1);
        pulse(I_UV, D); tick(1);
        expect_out("R6 uv latches in suspend", 0, 1, 0, 3'd4);
        pulse(I_COOL, 1); tick(1);
        expect_out("R7 code moves to uv", 0, 1, 0, 3'd3);
        pulse(I_EN, 1); tick(1);
        expect_out("R2 uv cleared by en", 1, 0, 0, 3'd0);

        // R7 first captured kept
        pulse(I_UV, D); tick(1);
        pulse(I_OC, D); tick(1);
        expect_out("R7 uv first kept", 0, 1, 0, 3'd3);
        pulse(I_EN, 1); tick(1);
        expect_out("R7 all cleared", 1, 0, 0, 3'd0);

        // R8 supply reset overrides a held fault flag and restarts counting
        drv[I_POR] = 1'b1;
        drv[I_OC]  = 1'b1;
        tick(D + 3);
        drv[I_POR] = 1'b0;
        tick(D - 2);
        drv[I_OC]  = 1'b0;
        tick(2);
        expect_out("R8 por overrides and restarts", 1, 0, 0, 3'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule